// File: doc/BRIEF.md
# Byte-Granular Burst Command Splitter

This block sits in front of the address channel of a memory-mapped bus master. A user hands it one command: a start byte address and a length in bytes. Neither value has to be aligned, and the length may be odd. The block rounds the start down to a bus-word boundary and works out how many bus words the byte range touches. It then issues that range as a series of address-channel bursts. Each burst carries a word-aligned address and a length field that holds the beat count minus one.

A burst never exceeds a configurable beat limit and never crosses a 4 KB page. The block stops issuing when the number of unanswered bursts reaches a configurable ceiling. It collects one response per burst. When the last response has arrived, it reports the command with a single done pulse, or with a single error pulse if any burst failed. Every burst also carries the byte offsets of its first and last valid bytes, so that a separate data path can build strobes or extract bytes. One instance serves one direction.

Top module: `burst_splitter`

## Requirements
- R1: `cmd_ready` is high whenever no command is held. A command is accepted on a cycle where `cmd_valid` and `cmd_ready` are both high. After a nonzero-size command is accepted, `cmd_ready` stays low until its completion pulse.
- R2: The first burst of a command carries the address `cmd_addr` rounded down to a multiple of BYTES. Each following burst starts at the word right after the previous burst.
- R3: The beats of all bursts of a command add up to floor((cmd_addr mod BYTES + cmd_size - 1) / BYTES) + 1. `bst_len` equals the beat count of the burst minus one.
- R4: No burst has more than MAX_BEATS beats. Each burst takes as many beats as the remaining count, the beat limit and the page boundary allow.
- R5: No burst crosses a 4 KB address boundary.
- R6: The number of bursts handed over on `bst_valid`/`bst_ready` that have not yet been answered on `rsp_valid` never exceeds MAX_OUTST.
- R7: Once every burst of a command has been answered, exactly one completion pulse follows, lasting one cycle. It is `error` if any response had `rsp_err` high, and `done` otherwise. The two are never high together.
- R8: A command with `cmd_size` = 0 issues no burst. `done` is high in the cycle after it is accepted.
- R9: `bst_first_ofs` is cmd_addr mod BYTES on the first burst and 0 on all others. `bst_last_ofs` is (cmd_addr + cmd_size - 1) mod BYTES on the last burst and BYTES-1 on all others.
- R10: While `bst_valid` is high and `bst_ready` is low, the next cycle still has `bst_valid` high with the same address and length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_addr | input | ADDR_W | Start byte address |
| cmd_size | input | SIZE_W | Transfer length in bytes |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be taken |
| bst_addr | output | ADDR_W | Word-aligned burst address |
| bst_len | output | LEN_W | Burst beats minus one |
| bst_first_ofs | output | OFS_W | Byte offset of first valid byte in first beat |
| bst_last_ofs | output | OFS_W | Byte offset of last valid byte in last beat |
| bst_valid | output | 1 | Burst command offered |
| bst_ready | input | 1 | Burst command taken |
| rsp_valid | input | 1 | One burst response |
| rsp_err | input | 1 | That burst failed |
| done | output | 1 | Command completed without error (pulse) |
| error | output | 1 | Command completed with an error (pulse) |

## Verification
The bench builds the block with 4-byte words, a 4-beat burst limit, at most 2 bursts outstanding, a 16-bit address and an 8-bit size. With a 4-beat limit, transfers of a few dozen bytes already split into several bursts. The bench sweeps every start address from 16 bytes below a 4 KB page to 8 bytes above it, and every size from 0 to 40 bytes. This covers every start offset and end offset within a word, splits forced by the page alone, by the beat limit alone, and by both together. The ready and response inputs follow irregular patterns, so the outstanding ceiling is reached and the burst must be held. Error flags are injected on chosen bursts.

// File: rtl/burst_splitter.sv
module burst_splitter #(
  parameter int ADDR_W    = 32,
  parameter int SIZE_W    = 16,
  parameter int BYTES     = 8,
  parameter int MAX_BEATS = 16,
  parameter int MAX_OUTST = 4,
  localparam int OFS_W  = (BYTES > 1) ? $clog2(BYTES) : 1,
  localparam int LEN_W  = (MAX_BEATS > 1) ? $clog2(MAX_BEATS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [SIZE_W-1:0] cmd_size,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  output logic [ADDR_W-1:0] bst_addr,
  output logic [LEN_W-1:0]  bst_len,
  output logic [OFS_W-1:0]  bst_first_ofs,
  output logic [OFS_W-1:0]  bst_last_ofs,
  output logic              bst_valid,
  input  logic              bst_ready,
  input  logic              rsp_valid,
  input  logic              rsp_err,
  output logic              done,
  output logic              error
);
  localparam int WA_W   = ADDR_W - OFS_W;
  localparam int BEAT_W = SIZE_W - OFS_W + 1;
  localparam int PG_W   = 12 - OFS_W;
  localparam int WPP    = 1 << PG_W;
  localparam int OUT_W  = $clog2(MAX_OUTST + 1);

  logic              busy, first, err_acc, done_q, err_q;
  logic [BEAT_W-1:0] words_left;
  logic [WA_W-1:0]   cur_word;
  logic [OFS_W-1:0]  start_ofs, end_ofs;
  logic [OUT_W-1:0]  outst;

  logic [SIZE_W:0]   span;
  logic [BEAT_W-1:0] need;
  logic [31:0]       left32, room32, n32;
  logic              accept, fire, rsp_ok, finish, last_bst;

  assign span   = {1'b0, cmd_size} + (SIZE_W+1)'(cmd_addr[OFS_W-1:0]) - 1'b1;
  assign need   = BEAT_W'(span[SIZE_W:OFS_W]) + 1'b1;

  assign left32 = 32'(words_left);
  assign room32 = 32'(WPP) - 32'(cur_word[PG_W-1:0]);
  always_comb begin
    n32 = left32;
    if (n32 > 32'(MAX_BEATS)) n32 = 32'(MAX_BEATS);
    if (n32 > room32)         n32 = room32;
  end
  assign last_bst = (n32 == left32);

  assign cmd_ready     = !busy;
  assign bst_valid     = busy && (words_left != '0) && (32'(outst) < 32'(MAX_OUTST));
  assign bst_addr      = {cur_word, {OFS_W{1'b0}}};
  assign bst_len       = LEN_W'(n32 - 32'd1);
  assign bst_first_ofs = first ? start_ofs : '0;
  assign bst_last_ofs  = last_bst ? end_ofs : OFS_W'(BYTES - 1);
  assign done          = done_q;
  assign error         = err_q;

  assign accept = cmd_valid && cmd_ready;
  assign fire   = bst_valid && bst_ready;
  assign rsp_ok = rsp_valid && (outst != '0);
  assign finish = busy && (words_left == '0) && (outst == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      first      <= 1'b0;
      err_acc    <= 1'b0;
      done_q     <= 1'b0;
      err_q      <= 1'b0;
      words_left <= '0;
      cur_word   <= '0;
      start_ofs  <= '0;
      end_ofs    <= '0;
      outst      <= '0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      if (accept) begin
        if (cmd_size == '0) begin
          done_q <= 1'b1;
        end else begin
          busy       <= 1'b1;
          first      <= 1'b1;
          err_acc    <= 1'b0;
          cur_word   <= cmd_addr[ADDR_W-1:OFS_W];
          words_left <= need;
          start_ofs  <= cmd_addr[OFS_W-1:0];
          end_ofs    <= span[OFS_W-1:0];
        end
      end
      if (fire) begin
        cur_word   <= cur_word + WA_W'(n32);
        words_left <= words_left - BEAT_W'(n32);
        first      <= 1'b0;
      end
      outst <= outst + OUT_W'(fire) - OUT_W'(rsp_ok);
      if (rsp_ok && rsp_err) err_acc <= 1'b1;
      if (finish) begin
        busy   <= 1'b0;
        done_q <= !err_acc;
        err_q  <= err_acc;
      end
    end
  end

  p_ready_while_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    bst_valid |-> !cmd_ready);
  p_outst_limit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    32'(outst) <= 32'(MAX_OUTST));
  p_no_page_cross_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bst_valid |-> (32'(bst_addr[11:OFS_W]) + 32'(bst_len)) < 32'(WPP));
  p_single_outcome_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && error));
  p_done_after_all_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done || error) |-> (outst == '0 && !bst_valid));
  p_zero_size_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && cmd_size == '0) |=> (done && !bst_valid));
  p_hold_burst_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bst_valid && !bst_ready) |=> (bst_valid && $stable(bst_addr) && $stable(bst_len)));
endmodule

// File: tb/tb_burst_splitter.sv
module tb_burst_splitter;
  localparam int AW = 16, SW = 8, B = 4, MB = 4, MO = 2;

  logic clk = 0, rst_n = 0;
  logic [AW-1:0] cmd_addr = '0;
  logic [SW-1:0] cmd_size = '0;
  logic cmd_valid = 0, bst_ready = 0, rsp_valid = 0, rsp_err = 0;
  logic cmd_ready, bst_valid, done, error;
  logic [AW-1:0] bst_addr;
  logic [1:0] bst_len, bst_first_ofs, bst_last_ofs;

  int compared = 0, mismatched = 0, tick = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  burst_splitter #(.ADDR_W(AW), .SIZE_W(SW), .BYTES(B), .MAX_BEATS(MB), .MAX_OUTST(MO)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_addr(cmd_addr), .cmd_size(cmd_size),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .bst_addr(bst_addr), .bst_len(bst_len),
    .bst_first_ofs(bst_first_ofs), .bst_last_ofs(bst_last_ofs), .bst_valid(bst_valid),
    .bst_ready(bst_ready), .rsp_valid(rsp_valid), .rsp_err(rsp_err), .done(done), .error(error));

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run(input int a, input int s, input bit ecmd, input int eat);
    int ew[64], en[64];
    int nb, word, left, k, pend, ridx, pa, pl;
    bit got, rdy_bad, outst_bad, hold, eerr;
    nb = 0;
    if (s > 0) begin
      word = a / B;
      left = ((a % B) + s - 1) / B + 1;
      while (left > 0) begin
        int n;
        n = left;
        if (n > MB) n = MB;
        if (n > 1024 - (word % 1024)) n = 1024 - (word % 1024);
        ew[nb] = word; en[nb] = n; nb++;
        word += n; left -= n;
      end
    end
    eerr = ecmd && (eat < nb);
    chk(cmd_ready == 1, "R1 idle ready", cmd_ready, 1);
    cmd_addr = AW'(a); cmd_size = SW'(s); cmd_valid = 1;
    @(negedge clk);
    cmd_valid = 0;
    if (s == 0) begin
      chk(done == 1 && error == 0, "R8 zero-size done", {error, done}, 1);
      chk(bst_valid == 0, "R8 no burst", bst_valid, 0);
      return;
    end
    k = 0; pend = 0; ridx = 0; got = 0; rdy_bad = 0; outst_bad = 0; hold = 0; pa = 0; pl = 0;
    for (int c = 0; c < 400; c++) begin
      if (done || error) begin got = 1; break; end
      if (cmd_ready) rdy_bad = 1;
      bst_ready = ((tick * 7) % 5) != 0;
      if (pend > 0 && ((tick * 3) % 4) != 1) begin
        rsp_valid = 1; rsp_err = ecmd && (ridx == eat); ridx++; pend--;
      end else begin
        rsp_valid = 0; rsp_err = 0;
      end
      #1;
      if (hold)
        chk(bst_valid && int'(bst_addr) == pa && int'(bst_len) == pl, "R10 held burst",
            bst_addr, pa);
      hold = bst_valid && !bst_ready;
      pa = int'(bst_addr); pl = int'(bst_len);
      if (bst_valid && bst_ready) begin
        if (k < nb) begin
          chk(int'(bst_addr) == ((ew[k] * B) & 16'hFFFF), "R2 burst address", bst_addr, ew[k] * B);
          chk(int'(bst_len) == en[k] - 1, "R3 R4 R5 burst length", bst_len, en[k] - 1);
          chk(int'(bst_first_ofs) == ((k == 0) ? a % B : 0), "R9 first offset",
              bst_first_ofs, (k == 0) ? a % B : 0);
          chk(int'(bst_last_ofs) == ((k == nb - 1) ? (a + s - 1) % B : B - 1), "R9 last offset",
              bst_last_ofs, (k == nb - 1) ? (a + s - 1) % B : B - 1);
        end
        k++; pend++;
      end
      if (pend > MO) outst_bad = 1;
      @(negedge clk);
    end
    bst_ready = 0; rsp_valid = 0; rsp_err = 0;
    chk(got, "R7 completion seen", got, 1);
    chk(k == nb, "R3 burst count", k, nb);
    chk(!rdy_bad, "R1 ready low while held", rdy_bad, 0);
    chk(!outst_bad, "R6 outstanding limit", outst_bad, 0);
    chk(error == eerr && done == !eerr, "R7 outcome", {error, done}, eerr ? 2 : 1);
    @(negedge clk);
    chk(done == 0 && error == 0, "R7 single pulse", {error, done}, 0);
  endtask

  always @(posedge clk) tick++;

  initial begin
    int ci;
    repeat (3) @(negedge clk);
    chk(cmd_ready == 1 && bst_valid == 0 && done == 0 && error == 0, "R1 reset state",
        {cmd_ready, bst_valid, done, error}, 8);
    rst_n = 1;
    @(negedge clk);
    ci = 0;
    for (int a = 16'h0FF0; a < 16'h1008; a++)
      for (int s = 0; s <= 40; s++) begin
        run(a, s, (ci % 4) == 3, ci % 3);
        ci++;
      end
    run(16'h0F03, 255, 0, 0);
    run(16'h0C02, 255, 1, 5);
    run(16'h0001, 1, 0, 0);
    run(16'h0003, 2, 1, 0);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      compared++; mismatched++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule